// File: doc/BRIEF.md
# Fill-Order Victim Way Selector

This block picks which way of one set in an N-way set-associative cache receives the next line fill. The cache presents the addressed set index, the per-word valid bits of every way in that set and each way's lock bit. The block answers in the same cycle with a victim way index and a flag that says whether any way may be replaced. An empty way is always preferred. When the set is full, locked ways are skipped and the remaining way that was filled longest ago is chosen. Access recency plays no part in the choice.

The block keeps a fill-order rank for every way of every set. When the fill logic writes a new tag, it raises a one-cycle commit strobe together with the way it filled. The rank state of the addressed set is updated on that clock edge, so the filled way becomes the youngest in its set. Tag comparison, line storage and the sequencing of the fill are left to neighbouring logic. A direct-mapped build keeps no rank state and always names way 0.

Top module: `lrf_victim_sel`

## Requirements
- R1: A way counts as empty only when all of its per-word valid bits are zero. Way w owns bits `word_valid[w*WORDS +: WORDS]`, and a single set bit makes the way valid.
- R2: When at least one way of the set is empty, the victim is the empty way with the lowest index and `victim_ok` is 1. Lock bits and fill order are ignored in this case.
- R3: When every way is valid, a way whose lock bit is 1 is never named as victim while `victim_ok` is 1.
- R4: When every way is valid and every way is locked, `victim_ok` is 0 and `victim_way` is 0.
- R5: When every way is valid and at least one is unlocked, the victim is the unlocked way with the lowest fill rank, which is the one filled longest ago, and `victim_ok` is 1.
- R6: After reset, the rank of way w in every set equals w, so way 0 is the oldest and way N-1 the youngest.
- R7: A clock edge with `fill_commit` high gives the way on `fill_way` rank N-1 in the set on `set_idx`. Every way of that set whose rank was above the filled way's old rank drops by one, and the other ways keep theirs. Filling the youngest way therefore changes nothing. The new order is seen from the following cycle.
- R8: A fill commit leaves the fill order of every other set unchanged.
- R9: With WAYS = 1, `victim_way` is always 0 and `victim_ok` is always 1, whatever the valid, lock and fill inputs are.
- R10: The victim outputs depend only on the current inputs and the stored ranks, with no register in the selection path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the rank state |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_idx | input | max(1,log2 SETS) | Addressed set, used both for selection and for rank update |
| word_valid | input | WAYS*WORDS | Per-word valid bits of the set, way-major |
| way_lock | input | WAYS | Lock bit per way of the set |
| fill_commit | input | 1 | One-cycle strobe: a new tag is being written into `fill_way` |
| fill_way | input | max(1,log2 WAYS) | Way that the committed fill wrote |
| victim_way | output | max(1,log2 WAYS) | Chosen way for the next fill |
| victim_ok | output | 1 | 1 when some way of the set may be replaced |

## Verification
On every cycle, the assertions check that an empty set position wins and that it is the lowest empty one. They also check that a locked way is never offered from a full set, that the no-replacement flag is raised exactly when a full set is entirely locked, that the stored ranks of the addressed set stay a permutation, and that a committed fill makes its way the youngest. Only the bench's scenarios can show the actual oldest-first order after a sequence of fills and the reset order. The bench recovers that order at the ports by locking the oldest ways one at a time. The bench scenarios also cover the isolation of other sets, a repeated fill of the youngest way and the fixed answer of the direct-mapped build.

// File: rtl/lrf_pkg.sv
`timescale 1ns/1ps
package lrf_pkg;

   // Index width that never collapses to zero bits.
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/lrf_way_state.sv
`timescale 1ns/1ps
module lrf_way_state #(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned WORDS = 4
) (
   input  logic [WAYS*WORDS-1:0] word_valid,
   output logic [WAYS-1:0]       way_live
);

   // A way is live while any one of its words holds data.
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign way_live[w] = |word_valid[w*WORDS +: WORDS];
   end

endmodule

// File: rtl/lrf_rank_store.sv
`timescale 1ns/1ps
module lrf_rank_store
   import lrf_pkg::*;
#(
   parameter int unsigned WAYS = 4,
   parameter int unsigned SETS = 64
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [idx_bits(SETS)-1:0]      set_idx,
   input  logic                           fill_en,
   input  logic [idx_bits(WAYS)-1:0]      fill_way,
   output logic [WAYS*idx_bits(WAYS)-1:0] rank_flat
);

   localparam int unsigned WAY_W = idx_bits(WAYS);
   localparam int unsigned SET_W = idx_bits(SETS);
   localparam logic [WAY_W-1:0] YOUNGEST = WAY_W'(WAYS - 1);

   logic [WAY_W-1:0] rank_q [SETS][WAYS];
   logic [WAY_W-1:0] old_rank;

   assign old_rank = rank_q[set_idx][fill_way];

   for (genvar w = 0; w < WAYS; w++) begin : g_rd
      assign rank_flat[w*WAY_W +: WAY_W] = rank_q[set_idx][w];
   end

   // Reset order: way index equals rank. On a fill the written way moves
   // to the youngest slot and the ways that were younger shift down.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
               rank_q[s][w] <= WAY_W'(w);
            end
         end
      end else if (fill_en) begin
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == fill_way) begin
               rank_q[set_idx][w] <= YOUNGEST;
            end else if (rank_q[set_idx][w] > old_rank) begin
               rank_q[set_idx][w] <= rank_q[set_idx][w] - WAY_W'(1);
            end
         end
      end
   end

   // ---------------- checks ----------------
   logic             chk_fill_q;
   logic [SET_W-1:0] chk_set_q;
   logic [WAY_W-1:0] chk_way_q;
   logic [WAYS-1:0]  rank_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_fill_q <= 1'b0;
         chk_set_q  <= '0;
         chk_way_q  <= '0;
      end else begin
         chk_fill_q <= fill_en;
         chk_set_q  <= set_idx;
         chk_way_q  <= fill_way;
      end
   end

   always_comb begin
      rank_seen = '0;
      for (int w = 0; w < WAYS; w++) begin
         rank_seen[rank_flat[w*WAY_W +: WAY_W]] = 1'b1;
      end
   end

   // R7: a committed fill leaves its way as the youngest of its set.
   a_r7_filled_is_youngest: assert property (@(posedge clk) disable iff (!rst_n)
      chk_fill_q |-> (rank_q[chk_set_q][chk_way_q] == YOUNGEST));

   // R6 / R7: ranks of the addressed set remain a permutation of 0..N-1.
   a_r7_rank_permutation: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rank_seen) == WAYS);

endmodule

// File: rtl/lrf_pick.sv
`timescale 1ns/1ps
module lrf_pick
   import lrf_pkg::*;
#(
   parameter int unsigned WAYS = 4
) (
   input  logic [WAYS-1:0]                way_live,
   input  logic [WAYS-1:0]                way_lock,
   input  logic [WAYS*idx_bits(WAYS)-1:0] rank_flat,
   output logic [idx_bits(WAYS)-1:0]      victim_way,
   output logic                           victim_ok
);

   localparam int unsigned WAY_W = idx_bits(WAYS);

   logic             dead_found;
   logic [WAY_W-1:0] dead_way;
   logic             old_found;
   logic [WAY_W-1:0] old_way;
   logic [WAY_W-1:0] old_rank;

   // Lowest-index empty way, scanning upward from way 0.
   always_comb begin
      dead_found = 1'b0;
      dead_way   = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (!way_live[w] && !dead_found) begin
            dead_found = 1'b1;
            dead_way   = WAY_W'(w);
         end
      end
   end

   // Oldest unlocked way by fill rank.
   always_comb begin
      old_found = 1'b0;
      old_way   = '0;
      old_rank  = '1;
      for (int w = 0; w < WAYS; w++) begin
         if (!way_lock[w] &&
             (!old_found || (rank_flat[w*WAY_W +: WAY_W] < old_rank))) begin
            old_found = 1'b1;
            old_way   = WAY_W'(w);
            old_rank  = rank_flat[w*WAY_W +: WAY_W];
         end
      end
   end

   always_comb begin
      if (dead_found) begin
         victim_way = dead_way;
         victim_ok  = 1'b1;
      end else if (old_found) begin
         victim_way = old_way;
         victim_ok  = 1'b1;
      end else begin
         victim_way = '0;
         victim_ok  = 1'b0;
      end
   end

endmodule

// File: rtl/lrf_victim_sel.sv
`timescale 1ns/1ps
module lrf_victim_sel
   import lrf_pkg::*;
#(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned WORDS = 4,
   parameter int unsigned SETS  = 64
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [idx_bits(SETS)-1:0]   set_idx,
   input  logic [WAYS*WORDS-1:0]       word_valid,
   input  logic [WAYS-1:0]             way_lock,
   input  logic                        fill_commit,
   input  logic [idx_bits(WAYS)-1:0]   fill_way,
   output logic [idx_bits(WAYS)-1:0]   victim_way,
   output logic                        victim_ok
);

   localparam int unsigned WAY_W = idx_bits(WAYS);

   // Elaboration-time parameter checks.
   if (!is_pow2(WAYS)) begin : g_bad_ways
      $error("lrf_victim_sel: WAYS must be a power of two");
   end
   if (WORDS < 1) begin : g_bad_words
      $error("lrf_victim_sel: WORDS must be at least 1");
   end
   if (!is_pow2(SETS)) begin : g_bad_sets
      $error("lrf_victim_sel: SETS must be a power of two");
   end

   if (WAYS == 1) begin : g_direct
      // R9: one way, no policy.
      logic unused_dm;
      assign unused_dm  = ^{clk, rst_n, set_idx, word_valid, way_lock,
                            fill_commit, fill_way};
      assign victim_way = '0;
      assign victim_ok  = 1'b1;
   end else begin : g_assoc
      logic [WAYS-1:0]       way_live;
      logic [WAYS*WAY_W-1:0] rank_flat;
      logic [WAYS-1:0]       below_mask;

      lrf_way_state #(.WAYS(WAYS), .WORDS(WORDS)) u_state (
         .word_valid (word_valid),
         .way_live   (way_live)
      );

      lrf_rank_store #(.WAYS(WAYS), .SETS(SETS)) u_rank (
         .clk       (clk),
         .rst_n     (rst_n),
         .set_idx   (set_idx),
         .fill_en   (fill_commit),
         .fill_way  (fill_way),
         .rank_flat (rank_flat)
      );

      lrf_pick #(.WAYS(WAYS)) u_pick (
         .way_live   (way_live),
         .way_lock   (way_lock),
         .rank_flat  (rank_flat),
         .victim_way (victim_way),
         .victim_ok  (victim_ok)
      );

      assign below_mask = (WAYS'(1) << victim_way) - WAYS'(1);

      // R2: an empty way wins and it is the lowest empty one.
      a_r2_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
         !(&way_live) |-> (victim_ok && !way_live[victim_way] &&
                           ((way_live & below_mask) == below_mask)));

      // R3: a full set never offers a locked way.
      a_r3_no_locked_victim: assert property (@(posedge clk) disable iff (!rst_n)
         (&way_live && victim_ok) |-> !way_lock[victim_way]);

      // R4: full and fully locked set gives no victim, way 0 on the output.
      a_r4_all_locked: assert property (@(posedge clk) disable iff (!rst_n)
         (&way_live && &way_lock) |-> (!victim_ok && (victim_way == '0)));

      // R4: the flag drops only for a full, fully locked set.
      a_r4_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
         !victim_ok |-> (&way_live && &way_lock));
   end

endmodule

// File: tb/lrf_victim_sel_test.sv
`timescale 1ns/1ps
module lrf_victim_sel_test;

   localparam int W  = 4;
   localparam int WD = 4;
   localparam int S  = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  set_idx = '0;
   logic [15:0] word_valid = '1;
   logic [3:0]  way_lock = '0;
   logic        fill_commit = 1'b0;
   logic [1:0]  fill_way = '0;
   logic [1:0]  victim_way;
   logic        victim_ok;

   logic [1:0]  dm_set = '0;
   logic [3:0]  dm_valid = '0;
   logic        dm_lock = 1'b0;
   logic        dm_fill = 1'b0;
   logic        dm_fill_way = 1'b0;
   logic        dm_victim;
   logic        dm_ok;

   int n_checks = 0;
   int n_err    = 0;
   bit done     = 0;
   int mrank [S][W];

   always #2.5 clk = ~clk;

   lrf_victim_sel #(.WAYS(W), .WORDS(WD), .SETS(S)) uut (
      .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .word_valid(word_valid),
      .way_lock(way_lock), .fill_commit(fill_commit), .fill_way(fill_way),
      .victim_way(victim_way), .victim_ok(victim_ok));

   lrf_victim_sel #(.WAYS(1), .WORDS(WD), .SETS(4)) dm (
      .clk(clk), .rst_n(rst_n), .set_idx(dm_set), .word_valid(dm_valid),
      .way_lock(dm_lock), .fill_commit(dm_fill), .fill_way(dm_fill_way),
      .victim_way(dm_victim), .victim_ok(dm_ok));

   task automatic expect_sel(input string req, input int s, input logic [15:0] wv,
                             input logic [3:0] lk, input int ew, input bit eok);
      @(negedge clk);
      set_idx    = 6'(s);
      word_valid = wv;
      way_lock   = lk;
      #1;
      n_checks++;
      if (victim_ok !== eok || (eok && victim_way !== 2'(ew)) ||
          (!eok && victim_way !== 2'd0)) begin
         n_err++;
         $display("FAIL %s: set %0d actual way=%0d ok=%0d expected way=%0d ok=%0d",
                  req, s, victim_way, victim_ok, (eok ? ew : 0), eok);
      end
   endtask

   // Expected choice from the requirements and the bench's own rank model.
   task automatic model_sel(input int s, input logic [15:0] wv, input logic [3:0] lk,
                            output int ew, output bit eok);
      ew = 0; eok = 0;
      for (int w = 0; w < W; w++) begin
         if (wv[w*WD +: WD] == '0) begin
            ew = w; eok = 1; return;
         end
      end
      for (int w = 0; w < W; w++) begin
         if (!lk[w] && (!eok || mrank[s][w] < mrank[s][ew])) begin
            ew = w; eok = 1;
         end
      end
   endtask

   task automatic model_check(input string req, input int s,
                              input logic [15:0] wv, input logic [3:0] lk);
      int ew; bit eok;
      model_sel(s, wv, lk, ew, eok);
      expect_sel(req, s, wv, lk, ew, eok);
   endtask

   // Walks the fill order of a full set by locking the oldest ways in turn.
   task automatic check_order(input string req, input int s);
      logic [3:0] lk = '0;
      for (int k = 0; k < W; k++) begin
         int ew; bit eok;
         model_sel(s, 16'hFFFF, lk, ew, eok);
         expect_sel(req, s, 16'hFFFF, lk, ew, eok);
         lk[ew] = 1'b1;
      end
      expect_sel({req, "/R4"}, s, 16'hFFFF, lk, 0, 0);
   endtask

   task automatic do_fill(input int s, input int w);
      int old;
      @(negedge clk);
      set_idx     = 6'(s);
      fill_way    = 2'(w);
      fill_commit = 1'b1;
      @(negedge clk);
      fill_commit = 1'b0;
      old = mrank[s][w];
      for (int v = 0; v < W; v++) begin
         if (v == w) mrank[s][v] = W - 1;
         else if (mrank[s][v] > old) mrank[s][v]--;
      end
   endtask

   task automatic t_reset_order();
      // R6: rank equals way index after reset.
      expect_sel("R6", 0, 16'hFFFF, 4'b0000, 0, 1);
      expect_sel("R6", 17, 16'hFFFF, 4'b0001, 1, 1);
      expect_sel("R6", 63, 16'hFFFF, 4'b0011, 2, 1);
      expect_sel("R6", 63, 16'hFFFF, 4'b0111, 3, 1);
      check_order("R6", 40);
   endtask

   task automatic t_empty_ways();
      // R1: way1 has only word 0 valid, so it counts as valid; way3 empty.
      expect_sel("R1", 3, 16'h0F1F, 4'b0000, 3, 1);
      // R1: way3 has only word 3 valid, set is full, oldest way 0 wins.
      expect_sel("R1", 3, 16'h8FFF, 4'b0000, 0, 1);
      // R2: lowest empty way even when locked.
      expect_sel("R2", 3, 16'hF0F0, 4'b0001, 0, 1);
      expect_sel("R2", 3, 16'h00FF, 4'b1100, 2, 1);
      expect_sel("R2", 3, 16'h0000, 4'b1111, 0, 1);
   endtask

   task automatic t_locks();
      expect_sel("R3", 9, 16'hFFFF, 4'b1011, 2, 1);
      expect_sel("R5", 9, 16'hFFFF, 4'b1001, 1, 1);
      expect_sel("R4", 9, 16'hFFFF, 4'b1111, 0, 0);
      expect_sel("R10", 9, 16'hFFFF, 4'b0000, 0, 1);
   endtask

   task automatic t_fill_order();
      do_fill(5, 0);
      expect_sel("R7", 5, 16'hFFFF, 4'b0000, 1, 1);
      do_fill(5, 2);
      expect_sel("R7", 5, 16'hFFFF, 4'b0010, 3, 1);
      do_fill(5, 1);
      expect_sel("R7", 5, 16'hFFFF, 4'b0000, 3, 1);
      expect_sel("R7", 5, 16'hFFFF, 4'b1000, 0, 1);
      expect_sel("R7", 5, 16'hFFFF, 4'b1001, 2, 1);
      // R7: refilling the youngest way keeps the order.
      do_fill(5, 1);
      check_order("R7", 5);
      // R8: neighbouring sets keep the reset order.
      expect_sel("R8", 6, 16'hFFFF, 4'b0000, 0, 1);
      check_order("R8", 4);
      // R2 still beats fill order in a reordered set.
      expect_sel("R2", 5, 16'hFF0F, 4'b0000, 1, 1);
   endtask

   task automatic t_fill_mix();
      for (int i = 0; i < 12; i++) begin
         do_fill(20 + (i % 3), (i * 3 + i / 4) % W);
      end
      for (int s = 20; s < 23; s++) check_order("R5", s);
      model_check("R3", 21, 16'hFFFF, 4'b0101);
   endtask

   task automatic t_direct();
      @(negedge clk);
      dm_valid = 4'h0; dm_lock = 1'b1;
      #1;
      n_checks++;
      if (dm_victim !== 1'b0 || dm_ok !== 1'b1) begin
         n_err++;
         $display("FAIL R9: actual way=%0d ok=%0d expected way=0 ok=1", dm_victim, dm_ok);
      end
      @(negedge clk);
      dm_valid = 4'hF; dm_set = 2'd2; dm_fill = 1'b1; dm_fill_way = 1'b1;
      @(negedge clk);
      dm_fill = 1'b0;
      #1;
      n_checks++;
      if (dm_victim !== 1'b0 || dm_ok !== 1'b1) begin
         n_err++;
         $display("FAIL R9: actual way=%0d ok=%0d expected way=0 ok=1", dm_victim, dm_ok);
      end
   endtask

   initial begin
      for (int s = 0; s < S; s++)
         for (int w = 0; w < W; w++) mrank[s][w] = w;
      repeat (4) @(posedge clk);
      #1;
      n_checks++;
      if (victim_way !== 2'd0 || victim_ok !== 1'b1) begin
         n_err++;
         $display("FAIL R6: reset actual way=%0d ok=%0d expected way=0 ok=1",
                  victim_way, victim_ok);
      end
      @(negedge clk);
      rst_n = 1'b1;
      t_reset_order();
      t_empty_ways();
      t_locks();
      t_fill_order();
      t_fill_mix();
      t_direct();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_checks++;
         n_err++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

endmodule